// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is purely combinational. It takes one byte operand, the current flag byte, a 4-bit operation code and a 3-bit bit index. In the same cycle it returns the modified byte and the updated flag byte.

Eight of the codes rotate or shift the operand. Two of these are circular rotates and two rotate through carry. The others are an arithmetic right shift, a logical right shift, a left shift that inserts zero, and a left shift that inserts one. Three further codes test, clear or set a single bit chosen by the index. The remaining codes leave both bytes unchanged.

The unit sits inside a processor datapath. Instruction decode chooses the code, and any memory read-modify-write is sequenced around the unit by other logic.

Top module: `rsb_unit`

## Requirements
- R1: Code 0 rotates left circularly: old bit 7 goes to both bit 0 and carry. Code 1 rotates right circularly: old bit 0 goes to both bit 7 and carry.
- R2: Code 2 rotates left through carry: incoming carry enters bit 0 and old bit 7 becomes carry. Code 3 rotates right through carry: incoming carry enters bit 7 and old bit 0 becomes carry.
- R3: Code 5 shifts right and keeps bit 7. Code 7 shifts right and fills bit 7 with zero. In both, old bit 0 becomes carry.
- R4: Code 4 shifts left and fills bit 0 with zero. Code 6 shifts left and fills bit 0 with one. In both, old bit 7 becomes carry.
- R5: The flag byte is laid out as bit 7 sign, bit 6 zero, bit 5 copy-5, bit 4 half-carry, bit 3 copy-3, bit 2 parity/overflow, bit 1 subtract and bit 0 carry. After codes 0 to 7:
  - sign, copy-5 and copy-3 equal result bits 7, 5 and 3;
  - zero is set when the result is 0;
  - parity/overflow is 1 when the result has an even number of ones;
  - half-carry and subtract are 0.
- R6: Code 8 tests the operand bit chosen by the index and returns the operand unchanged. The new flags are set as follows:
  - carry keeps its incoming value;
  - half-carry is 1 and subtract is 0;
  - copy-5 and copy-3 take operand bits 5 and 3;
  - zero and parity/overflow are both 1 when the tested bit is 0;
  - sign is 1 only when the index is 7 and operand bit 7 is 1.
- R7: Code 9 clears and code 10 sets the operand bit chosen by the index. No other bit changes, and the flag byte passes through unchanged.
- R8: Codes 11 to 15 return the operand and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 8 | Operand byte |
| flags_i | input | 8 | Incoming flag byte |
| op_i | input | 4 | Operation code |
| bit_idx_i | input | 3 | Bit position for codes 8 to 10 |
| result_o | output | 8 | Modified byte |
| flags_o | output | 8 | New flag byte |

## Verification
Some properties are checked by assertions on every evaluation:
- a left move keeps the body of the operand one place up, and a right move keeps it one place down;
- half-carry and subtract are clear after any shift;
- set and clear change at most the indexed bit;
- a bit test keeps carry and the operand, and its zero and parity flags agree, with sign raised only for index 7.

Other behaviour only the bench scenarios can show. This covers the exact bit that fills the vacated position for each of the eight shift codes, the use of the incoming carry in the through-carry rotates, parity over many patterns, and the pass-through of unassigned codes.

// File: rtl/rsb_pkg.sv
`timescale 1ns/1ps
package rsb_pkg;
  localparam int W      = 8;
  localparam int IDX_W  = $clog2(W);
  localparam int OP_W   = 4;
  localparam int KIND_W = 3;

  localparam logic [OP_W-1:0] OP_TEST  = 4'd8;
  localparam logic [OP_W-1:0] OP_CLR   = 4'd9;
  localparam logic [OP_W-1:0] OP_SET   = 4'd10;
  localparam logic [OP_W-1:0] OP_SHMAX = 4'd7;

  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_3  = 3;
  localparam int F_H  = 4;
  localparam int F_5  = 5;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;

  function automatic logic even_par(input logic [W-1:0] v);
    return ~(^v);
  endfunction

  // Flags produced by any rotate or shift.
  function automatic logic [W-1:0] shift_flags(input logic [W-1:0] v, input logic cy);
    logic [W-1:0] f;
    f       = '0;
    f[F_S]  = v[W-1];
    f[F_Z]  = (v == '0);
    f[F_5]  = v[5];
    f[F_3]  = v[3];
    f[F_PV] = even_par(v);
    f[F_C]  = cy;
    return f;
  endfunction

  // Flags produced by a bit test.
  function automatic logic [W-1:0] test_flags(input logic [W-1:0] v, input logic hit,
                                              input logic top_idx, input logic cin);
    logic [W-1:0] f;
    f       = '0;
    f[F_S]  = hit & top_idx;
    f[F_Z]  = ~hit;
    f[F_PV] = ~hit;
    f[F_5]  = v[5];
    f[F_3]  = v[3];
    f[F_H]  = 1'b1;
    f[F_C]  = cin;
    return f;
  endfunction
endpackage

// File: rtl/rsb_shift.sv
`timescale 1ns/1ps
module rsb_shift
  import rsb_pkg::*;
(
  input  logic [KIND_W-1:0] kind_i,
  input  logic [W-1:0]      opnd_i,
  input  logic              cin_i,
  output logic [W-1:0]      res_o,
  output logic [W-1:0]      flags_o
);
  logic          go_left;
  logic          fill_bit;
  logic          out_bit;
  logic [W-1:0]  res;

  assign go_left = ~kind_i[0];
  assign out_bit = go_left ? opnd_i[W-1] : opnd_i[0];

  always_comb begin
    unique case (kind_i)
      3'd0:    fill_bit = opnd_i[W-1];
      3'd1:    fill_bit = opnd_i[0];
      3'd2:    fill_bit = cin_i;
      3'd3:    fill_bit = cin_i;
      3'd4:    fill_bit = 1'b0;
      3'd5:    fill_bit = opnd_i[W-1];
      3'd6:    fill_bit = 1'b1;
      default: fill_bit = 1'b0;
    endcase
    if (go_left) res = {opnd_i[W-2:0], fill_bit};
    else         res = {fill_bit, opnd_i[W-1:1]};
  end

  assign res_o   = res;
  assign flags_o = shift_flags(res, out_bit);

  always_comb begin
    if (go_left)
      p_body_left_r1: assert (res_o[W-1:1] == opnd_i[W-2:0]) else $error("left body moved wrong");
    else
      p_body_right_r1: assert (res_o[W-2:0] == opnd_i[W-1:1]) else $error("right body moved wrong");
    p_hn_clear_r5: assert (flags_o[F_H] == 1'b0 && flags_o[F_N] == 1'b0) else $error("H/N not cleared");
    p_zero_r5: assert (flags_o[F_Z] == (res_o == '0)) else $error("zero flag wrong");
  end
endmodule

// File: rtl/rsb_bitop.sv
`timescale 1ns/1ps
module rsb_bitop
  import rsb_pkg::*;
(
  input  logic [W-1:0]     opnd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             cin_i,
  output logic [W-1:0]     clr_o,
  output logic [W-1:0]     set_o,
  output logic [W-1:0]     tflags_o
);
  logic [W-1:0] sel_mask;
  logic         hit;

  for (genvar g = 0; g < W; g++) begin : g_mask
    assign sel_mask[g] = (idx_i == IDX_W'(g));
  end

  assign hit      = |(opnd_i & sel_mask);
  assign clr_o    = opnd_i & ~sel_mask;
  assign set_o    = opnd_i | sel_mask;
  assign tflags_o = test_flags(opnd_i, hit, (idx_i == IDX_W'(W-1)), cin_i);

  always_comb begin
    p_single_set_r7: assert ($countones(set_o ^ opnd_i) <= 1 && (set_o & ~opnd_i & ~sel_mask) == '0)
      else $error("set touched other bits");
    p_single_clr_r7: assert ($countones(clr_o ^ opnd_i) <= 1 && (opnd_i & ~clr_o & ~sel_mask) == '0)
      else $error("clear touched other bits");
    p_zpv_agree_r6: assert (tflags_o[F_Z] == tflags_o[F_PV]) else $error("Z and PV disagree");
    p_sign_top_r6: assert (!tflags_o[F_S] || idx_i == IDX_W'(W-1)) else $error("sign for low index");
  end
endmodule

// File: rtl/rsb_unit.sv
`timescale 1ns/1ps
module rsb_unit
  import rsb_pkg::*;
(
  input  logic [7:0] opnd_i,
  input  logic [7:0] flags_i,
  input  logic [3:0] op_i,
  input  logic [2:0] bit_idx_i,
  output logic [7:0] result_o,
  output logic [7:0] flags_o
);
  logic [W-1:0] sh_res, sh_flags;
  logic [W-1:0] clr_res, set_res, tst_flags;
  logic         is_shift, is_test;

  assign is_shift = (op_i <= OP_SHMAX);
  assign is_test  = (op_i == OP_TEST);

  rsb_shift u_shift (
    .kind_i (op_i[KIND_W-1:0]),
    .opnd_i (opnd_i),
    .cin_i  (flags_i[F_C]),
    .res_o  (sh_res),
    .flags_o(sh_flags)
  );

  rsb_bitop u_bitop (
    .opnd_i  (opnd_i),
    .idx_i   (bit_idx_i),
    .cin_i   (flags_i[F_C]),
    .clr_o   (clr_res),
    .set_o   (set_res),
    .tflags_o(tst_flags)
  );

  always_comb begin
    result_o = opnd_i;
    flags_o  = flags_i;
    if (is_shift) begin
      result_o = sh_res;
      flags_o  = sh_flags;
    end else if (is_test) begin
      flags_o  = tst_flags;
    end else if (op_i == OP_CLR) begin
      result_o = clr_res;
    end else if (op_i == OP_SET) begin
      result_o = set_res;
    end
  end

  always_comb begin
    if (is_test)
      p_test_keeps_r6: assert (result_o == opnd_i && flags_o[F_C] == flags_i[F_C])
        else $error("bit test altered operand or carry");
    if (op_i == OP_CLR || op_i == OP_SET)
      p_flags_pass_r7: assert (flags_o == flags_i) else $error("bit change altered flags");
  end
endmodule

// File: tb/test_rsb_unit.sv
`timescale 1ns/1ps
module test_rsb_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0] opnd, flg, res, fo;
  logic [3:0] op;
  logic [2:0] idx;

  rsb_unit i_rsb_unit (
    .opnd_i(opnd), .flags_i(flg), .op_i(op), .bit_idx_i(idx),
    .result_o(res), .flags_o(fo)
  );

  logic [15:0] exp_q[$];
  string       tag_q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  function automatic bit par_even(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += v[i];
    return (c % 2) == 0;
  endfunction

  // Independent reference: returns {result, flags}.
  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] f, input logic [2:0] b);
    logic [7:0] r, nf;
    logic cy;
    r = a; nf = f; cy = 0;
    if (o < 8) begin
      case (o)
        0: begin r = (a << 1) | (a >> 7);          cy = a[7]; end // R1
        1: begin r = (a >> 1) | (a << 7);          cy = a[0]; end // R1
        2: begin r = (a << 1) | {7'd0, f[0]};      cy = a[7]; end // R2
        3: begin r = (a >> 1) | {f[0], 7'd0};      cy = a[0]; end // R2
        4: begin r = a << 1;                       cy = a[7]; end // R4
        5: begin r = (a >> 1) | (a & 8'h80);       cy = a[0]; end // R3
        6: begin r = (a << 1) | 8'h01;             cy = a[7]; end // R4
        default: begin r = a >> 1;                 cy = a[0]; end // R3
      endcase
      nf = {r[7], r == 8'h00, r[5], 1'b0, r[3], par_even(r), 1'b0, cy}; // R5
    end else if (o == 8) begin                                       // R6
      logic t;
      t  = a[b];
      nf = {(b == 3'd7) && t, !t, a[5], 1'b1, a[3], !t, 1'b0, f[0]};
    end else if (o == 9) r = a & ~(8'h01 << b);                      // R7
    else if (o == 10) r = a | (8'h01 << b);                          // R7
    return {r, nf};
  endfunction

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] f,
                       input logic [2:0] b, input string tag);
    @(posedge clk);
    #1;
    op = o; opnd = a; flg = f; idx = b;
    exp_q.push_back(model(o, a, f, b));
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if ({res, fo} !== e) begin
        n_bad++;
        $display("FAIL %s op=%0d a=%02h f=%02h idx=%0d: got res=%02h flags=%02h exp res=%02h flags=%02h",
                 t, op, opnd, flg, idx, res, fo, e[15:8], e[7:0]);
      end
    end
  end

  string tags[16] = '{"R1","R1","R2","R2","R4","R3","R4","R3","R6","R7","R7",
                      "R8","R8","R8","R8","R8"};
  logic [7:0] pats[8] = '{8'h00, 8'h80, 8'h01, 8'hFF, 8'hA5, 8'h5A, 8'h7F, 8'h28};

  initial begin
    op = 4'hF; opnd = 8'h3C; flg = 8'hC3; idx = 3'd0;
    // Reset-time check: unassigned code passes through (R8).
    drive(4'hF, 8'h3C, 8'hC3, 3'd0, "R8 reset");
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // Directed corners.
    drive(4'd0, 8'h80, 8'h00, 3'd0, "R1 rlc wrap");
    drive(4'd1, 8'h01, 8'h00, 3'd0, "R1 rrc wrap");
    drive(4'd2, 8'h00, 8'h01, 3'd0, "R2 rl carry in");
    drive(4'd3, 8'h00, 8'h01, 3'd0, "R2 rr carry in");
    drive(4'd5, 8'h81, 8'h00, 3'd0, "R3 sra keep sign");
    drive(4'd7, 8'h81, 8'h00, 3'd0, "R3 srl zero fill");
    drive(4'd4, 8'h80, 8'hFF, 3'd0, "R5 sla zero result");
    drive(4'd6, 8'h80, 8'h00, 3'd0, "R4 one fill");
    drive(4'd8, 8'h80, 8'h01, 3'd7, "R6 sign on bit7");
    drive(4'd8, 8'h7F, 8'h00, 3'd7, "R6 zero bit7");
    drive(4'd8, 8'hFF, 8'h00, 3'd3, "R6 no sign low idx");
    drive(4'd9, 8'hFF, 8'h5A, 3'd0, "R7 clear bit0");
    drive(4'd10, 8'h00, 8'hA5, 3'd7, "R7 set bit7");
    // Sweep all codes, patterns, both carry values, several indices.
    for (int o = 0; o < 16; o++)
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 2; c++)
          for (int b = 0; b < 8; b += 3)
            drive(4'(o), pats[p], c ? 8'hFF : 8'h00, 3'(b), tags[o]);
    for (int b = 0; b < 8; b++) begin
      drive(4'd8, 8'(1 << b), 8'h00, 3'(b), "R6 single hit");
      drive(4'd9, 8'hFF, 8'h11, 3'(b), "R7 clear sweep");
      drive(4'd10, 8'h00, 8'hEE, 3'(b), "R7 set sweep");
    end
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule